// File: doc/BRIEF.md
# Double-Buffered Endpoint Transmit Buffer

This block is the transmit-side store for one bulk-in endpoint. It has two packet banks of `BANK_BYTES` bytes (64 by default). The banks take turns. One is filled through a byte write port, which a memory-to-peripheral DMA engine drives, paced by the `dreq` request. The other bank waits for or feeds the serial engine. When the write that brings a bank to a full packet lands, the block commits that bank for sending without processor help. A short final packet stays uncommitted until software pulses `pkt_arm`. Arming a bank that holds nothing commits a zero-length packet.

On the read side, committed banks are drained in the order in which they were committed. Each bank reports its byte count as the packet length. The serial engine pulls bytes with `rd_en` and then acknowledges the packet with `pkt_ack`. That releases the bank for refilling and sets the sticky `tx_done` flag. The interrupt `irq` is gated only by `irq_en`; the DMA enable has no effect on it. Writes that arrive while both banks are committed are dropped and set the sticky `overflow` flag. Both sticky flags are cleared by `flag_clr`.

Each bank runs a four-state machine:

| State | Meaning |
|---|---|
| `BK_EMPTY` | Holds nothing. |
| `BK_FILL` | Holds a partial packet. |
| `BK_READY` | Committed, and no byte has been read yet. |
| `BK_DRAIN` | Committed, and reading has begun. |

Its transitions are:

| Transition | Cause |
|---|---|
| EMPTY→FILL | A write without an arm. |
| EMPTY→READY | An arm, or a full write. |
| FILL→READY | The last-byte write or an arm. |
| READY→DRAIN | The first read. |
| READY→EMPTY | Acknowledge of a zero-length packet. |
| DRAIN→EMPTY | Acknowledge after the last read. |

Every other input combination keeps the bank in its state.

A one-bit fill pointer selects the bank that takes writes. It toggles on each commit. A one-bit drain pointer selects the bank that feeds the read port. It toggles on each accepted acknowledge.

Top module: `ep_tx_dbuf`

## Requirements
- R1: After reset, `empty`=1 and `dreq`, `full`, `pkt_rdy`, `tx_done`, `overflow` and `irq` are all 0.
- R2: `dreq` is 1 exactly when `dma_en` is 1 and the bank being filled has at least one free byte. Clearing `dma_en` drops `dreq`.
- R3: The accepted write that brings the fill bank to `BANK_BYTES` bytes commits it automatically. It is then offered with `pkt_len` = `BANK_BYTES`.
- R4: A bank holding fewer than `BANK_BYTES` bytes stays uncommitted (`pkt_rdy` remains 0 for it) until `pkt_arm` is pulsed. It is then committed with `pkt_len` equal to the bytes written.
- R5: After a commit, writes go to the other bank. `dreq` stays 1 while that bank has space.
- R6: `pkt_arm` on a fill bank holding zero bytes commits a zero-length packet (`pkt_len`=0).
- R7: Packets leave in commit order. `rd_data` shows the next unread byte of the head packet, and `rd_en` advances it. A `pkt_ack` given after every byte has been read releases the bank and sets `tx_done`.
- R8: While both banks are committed, `full`=1 and `dreq`=0. Writes are dropped and set the sticky `overflow`. `pkt_arm` has no effect.
- R9: `irq` = `tx_done` AND `irq_en`, independent of `dma_en`. `flag_clr` clears `tx_done` and `overflow`; a set in the same cycle wins.
- R10: A write and a `pkt_arm` in the same cycle commit a packet that includes that byte.
- R11: A `pkt_ack` given before all bytes of the head packet are read is ignored.
- R12: `empty` is 1 exactly when both banks hold no bytes and no packet is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dma_en | input | 1 | DMA mode enable bit |
| irq_en | input | 1 | Interrupt enable bit |
| dreq | output | 1 | Transfer request to the DMA engine |
| wr_valid | input | 1 | Byte write strobe |
| wr_data | input | DATA_W | Byte to write |
| pkt_arm | input | 1 | Manual packet-enable strobe |
| flag_clr | input | 1 | Clears the sticky flags |
| pkt_rdy | output | 1 | A committed packet is at the read port |
| pkt_len | output | $clog2(BANK_BYTES+1) | Length of the head packet |
| rd_en | input | 1 | Read one byte of the head packet |
| rd_data | output | DATA_W | Next unread byte of the head packet |
| pkt_ack | input | 1 | Packet sent acknowledge |
| full | output | 1 | Neither bank can take data |
| empty | output | 1 | Both banks empty, nothing pending |
| tx_done | output | 1 | Sticky packet-sent flag |
| overflow | output | 1 | Sticky dropped-write flag |
| irq | output | 1 | Endpoint interrupt request |

## Verification
Two functions can fall in the same cycle: the commit of the fill bank, and the release of the drain bank through an accepted acknowledge. In the same way, a byte write and a manual arm can coincide on the fill bank. The random phase drives writes, arms, reads and acknowledges independently each cycle, so these pairs collide often. A directed case also issues a write together with an arm. A bench model keeps a fill queue, a committed-byte queue and a length queue. It is updated from the pre-edge state alone, and every output is compared with it one half-cycle after each edge.

// File: rtl/ep_tx_pkg.sv
package ep_tx_pkg;
    typedef enum logic [1:0] {
        BK_EMPTY = 2'd0,
        BK_FILL  = 2'd1,
        BK_READY = 2'd2,
        BK_DRAIN = 2'd3
    } bank_st_t;
endpackage

// File: rtl/ep_tx_bank.sv
module ep_tx_bank
    import ep_tx_pkg::*;
#(
    parameter int BANK_BYTES = 64,
    parameter int DATA_W     = 8,
    localparam int CW        = $clog2(BANK_BYTES + 1),
    localparam int AW        = $clog2(BANK_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic              arm_i,
    input  logic              rd_i,
    input  logic              ack_i,
    output logic [CW-1:0]     cnt_o,
    output logic [DATA_W-1:0] data_o,
    output logic              fillable_o,
    output logic              loaded_o,
    output logic              drained_o
);
    localparam logic [CW-1:0] LAST = CW'(BANK_BYTES - 1);

    bank_st_t          st, st_n;
    logic [CW-1:0]     cnt, cnt_n;
    logic [CW-1:0]     rptr, rptr_n;
    logic [DATA_W-1:0] mem [BANK_BYTES];

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st   <= BK_EMPTY;
            cnt  <= '0;
            rptr <= '0;
        end else begin
            st   <= st_n;
            cnt  <= cnt_n;
            rptr <= rptr_n;
        end
    end

    // byte store, written at the fill count
    always_ff @(posedge clk) begin
        if (wr_i && fillable_o) begin
            mem[cnt[AW-1:0]] <= wr_data_i;
        end
    end

    // next-state logic
    always_comb begin
        st_n   = st;
        cnt_n  = cnt;
        rptr_n = rptr;
        unique case (st)
            BK_EMPTY, BK_FILL: begin
                if (wr_i) begin
                    cnt_n = cnt + CW'(1);
                end
                if (arm_i || (wr_i && cnt == LAST)) begin
                    st_n = BK_READY;
                end else if (wr_i) begin
                    st_n = BK_FILL;
                end
            end
            BK_READY, BK_DRAIN: begin
                if (rd_i && rptr != cnt) begin
                    rptr_n = rptr + CW'(1);
                    st_n   = BK_DRAIN;
                end else if (ack_i && rptr == cnt) begin
                    st_n   = BK_EMPTY;
                    cnt_n  = '0;
                    rptr_n = '0;
                end
            end
        endcase
    end

    // outputs
    always_comb begin
        fillable_o = (st == BK_EMPTY) || (st == BK_FILL);
        loaded_o   = (st == BK_READY) || (st == BK_DRAIN);
        drained_o  = (rptr == cnt);
        cnt_o      = cnt;
        data_o     = mem[rptr[AW-1:0]];
    end

    p_auto_commit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (fillable_o && wr_i && cnt == LAST) |=> (st == BK_READY && cnt == CW'(BANK_BYTES)))
        else $error("R3: bank not committed on last byte");

    p_short_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (st == BK_FILL && !wr_i && !arm_i) |=> (st == BK_FILL && $stable(cnt)))
        else $error("R4: short packet changed without arm");

    p_zero_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st == BK_EMPTY && arm_i && !wr_i) |=> (st == BK_READY && cnt == '0))
        else $error("R6: zero-length arm failed");

    p_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (loaded_o && ack_i && drained_o) |=> (st == BK_EMPTY))
        else $error("R7: drained bank not released");

    p_early_ack_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (loaded_o && ack_i && !drained_o) |=> loaded_o)
        else $error("R11: early acknowledge released bank");
endmodule

// File: rtl/ep_tx_flags.sv
module ep_tx_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic set_done_i,
    input  logic set_ovf_i,
    input  logic clr_i,
    input  logic irq_en_i,
    output logic done_o,
    output logic ovf_o,
    output logic irq_o
);
    logic done_q, ovf_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q <= 1'b0;
            ovf_q  <= 1'b0;
        end else begin
            done_q <= set_done_i | (done_q & ~clr_i);
            ovf_q  <= set_ovf_i  | (ovf_q  & ~clr_i);
        end
    end

    always_comb begin
        done_o = done_q;
        ovf_o  = ovf_q;
        irq_o  = done_q & irq_en_i;
    end

    p_sticky_ovf_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_q && !clr_i) |=> ovf_q)
        else $error("R8: overflow flag not sticky");

    p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !set_done_i) |=> !done_q)
        else $error("R9: clear did not remove done flag");
endmodule

// File: rtl/ep_tx_dbuf.sv
module ep_tx_dbuf #(
    parameter int BANK_BYTES = 64,
    parameter int DATA_W     = 8,
    localparam int CW        = $clog2(BANK_BYTES + 1),
    localparam int NBANK     = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dma_en,
    input  logic              irq_en,
    output logic              dreq,
    input  logic              wr_valid,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              pkt_arm,
    input  logic              flag_clr,
    output logic              pkt_rdy,
    output logic [CW-1:0]     pkt_len,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    input  logic              pkt_ack,
    output logic              full,
    output logic              empty,
    output logic              tx_done,
    output logic              overflow,
    output logic              irq
);
    localparam logic [CW-1:0] LAST = CW'(BANK_BYTES - 1);

    logic              fill_sel, rd_sel;
    logic [CW-1:0]     b_cnt      [NBANK];
    logic [DATA_W-1:0] b_data     [NBANK];
    logic [NBANK-1:0]  b_fillable;
    logic [NBANK-1:0]  b_loaded;
    logic [NBANK-1:0]  b_drained;
    logic              fill_ok, commit_evt, rel_evt, drop_evt;

    always_comb begin
        fill_ok    = b_fillable[fill_sel];
        commit_evt = fill_ok && (pkt_arm || (wr_valid && b_cnt[fill_sel] == LAST));
        rel_evt    = b_loaded[rd_sel] && pkt_ack && b_drained[rd_sel];
        drop_evt   = wr_valid && !fill_ok;
    end

    // bank pointers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fill_sel <= 1'b0;
            rd_sel   <= 1'b0;
        end else begin
            if (commit_evt) fill_sel <= ~fill_sel;
            if (rel_evt)    rd_sel   <= ~rd_sel;
        end
    end

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        logic sel_w, sel_r;
        assign sel_w = (fill_sel == 1'(b));
        assign sel_r = (rd_sel == 1'(b));
        ep_tx_bank #(
            .BANK_BYTES(BANK_BYTES),
            .DATA_W    (DATA_W)
        ) i_bank (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_i      (wr_valid && sel_w),
            .wr_data_i (wr_data),
            .arm_i     (pkt_arm && sel_w),
            .rd_i      (rd_en && sel_r),
            .ack_i     (pkt_ack && sel_r),
            .cnt_o     (b_cnt[b]),
            .data_o    (b_data[b]),
            .fillable_o(b_fillable[b]),
            .loaded_o  (b_loaded[b]),
            .drained_o (b_drained[b])
        );
    end

    ep_tx_flags i_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_done_i(rel_evt),
        .set_ovf_i (drop_evt),
        .clr_i     (flag_clr),
        .irq_en_i  (irq_en),
        .done_o    (tx_done),
        .ovf_o     (overflow),
        .irq_o     (irq)
    );

    always_comb begin
        dreq    = dma_en && fill_ok;
        full    = !fill_ok;
        empty   = (b_cnt[0] == '0) && (b_cnt[1] == '0) && (b_loaded == '0);
        pkt_rdy = b_loaded[rd_sel];
        pkt_len = b_cnt[rd_sel];
        rd_data = b_data[rd_sel];
    end

    p_reject_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && full) |=> overflow)
        else $error("R8: dropped write did not flag overflow");

    p_refill_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_evt && b_cnt[!fill_sel] == '0 && !b_loaded[!fill_sel])
            |=> (dreq || !dma_en))
        else $error("R5: request not renewed for free bank");

    p_order_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rel_evt && b_loaded[!rd_sel]) |=> pkt_rdy)
        else $error("R7: second packet not offered after release");
endmodule

// File: tb/test_ep_tx_dbuf.sv
`timescale 1ns/1ps
module test_ep_tx_dbuf;
    localparam int BB = 64;
    localparam int DW = 8;
    localparam int CW = $clog2(BB + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          dma_en = 1'b0, irq_en = 1'b0;
    logic          wr_valid = 1'b0, pkt_arm = 1'b0, flag_clr = 1'b0;
    logic          rd_en = 1'b0, pkt_ack = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic          dreq, pkt_rdy, full, empty, tx_done, overflow, irq;
    logic [CW-1:0] pkt_len;
    logic [DW-1:0] rd_data;

    ep_tx_dbuf #(.BANK_BYTES(BB), .DATA_W(DW)) i_ep_tx_dbuf (
        .clk(clk), .rst_n(rst_n), .dma_en(dma_en), .irq_en(irq_en), .dreq(dreq),
        .wr_valid(wr_valid), .wr_data(wr_data), .pkt_arm(pkt_arm), .flag_clr(flag_clr),
        .pkt_rdy(pkt_rdy), .pkt_len(pkt_len), .rd_en(rd_en), .rd_data(rd_data),
        .pkt_ack(pkt_ack), .full(full), .empty(empty), .tx_done(tx_done),
        .overflow(overflow), .irq(irq)
    );

    always #10 clk = ~clk;

    int n_cmp = 0, n_bad = 0;

    // reference model
    int unsigned fill_q[$];
    int unsigned data_q[$];
    int          len_q[$];
    int          rd_cnt = 0;
    bit          m_done = 0, m_ovf = 0;

    function automatic bit m_fillable();
        return len_q.size() < 2;
    endfunction

    function automatic bit m_empty();
        return len_q.size() == 0 && fill_q.size() == 0;
    endfunction

    task automatic cmp(string tag, string what, int got, int exp);
        n_cmp++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, got, exp, $time);
        end
    endtask

    task automatic check_all();
        cmp("R2", "dreq", int'(dreq), int'(dma_en && m_fillable()));
        cmp("R8", "full", int'(full), int'(!m_fillable()));
        cmp("R12", "empty", int'(empty), int'(m_empty()));
        cmp("R7", "pkt_rdy", int'(pkt_rdy), int'(len_q.size() > 0));
        if (len_q.size() > 0) begin
            cmp("R3/R4", "pkt_len", int'(pkt_len), len_q[0]);
            if (rd_cnt < len_q[0]) cmp("R7", "rd_data", int'(rd_data), int'(data_q[0]));
        end
        cmp("R7", "tx_done", int'(tx_done), int'(m_done));
        cmp("R8", "overflow", int'(overflow), int'(m_ovf));
        cmp("R9", "irq", int'(irq), int'(m_done && irq_en));
    endtask

    // one clock: drive at the falling edge, model the rising edge, compare at the next falling edge
    task automatic step(bit w, int unsigned d, bit a, bit r, bit k, bit c);
        bit fl, s_done, s_ovf;
        wr_valid = w; wr_data = DW'(d); pkt_arm = a; rd_en = r; pkt_ack = k; flag_clr = c;
        fl = m_fillable();
        s_done = 0; s_ovf = 0;
        if (len_q.size() > 0) begin
            if (r && rd_cnt < len_q[0]) begin
                void'(data_q.pop_front());
                rd_cnt++;
            end else if (k && rd_cnt == len_q[0]) begin
                void'(len_q.pop_front());
                rd_cnt = 0;
                s_done = 1;
            end
        end
        if (w) begin
            if (fl) fill_q.push_back(d & 8'hFF);
            else    s_ovf = 1;
        end
        if (fl && (a || fill_q.size() == BB)) begin
            len_q.push_back(fill_q.size());
            foreach (fill_q[i]) data_q.push_back(fill_q[i]);
            fill_q.delete();
        end
        m_done = s_done | (m_done & !c);
        m_ovf  = s_ovf  | (m_ovf  & !c);
        @(posedge clk);
        @(negedge clk);
        wr_valid = 0; pkt_arm = 0; rd_en = 0; pkt_ack = 0; flag_clr = 0;
        check_all();
    endtask

    task automatic drain_all();
        while (len_q.size() > 0) begin
            if (rd_cnt < len_q[0]) step(0, 0, 0, 1, 0, 0);
            else                   step(0, 0, 0, 0, 1, 0);
        end
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual hang expected completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'h5EED_0A1B));
        repeat (3) @(negedge clk);
        // R1: reset state
        cmp("R1", "empty", int'(empty), 1);
        cmp("R1", "dreq", int'(dreq), 0);
        cmp("R1", "full", int'(full), 0);
        cmp("R1", "pkt_rdy", int'(pkt_rdy), 0);
        cmp("R1", "tx_done", int'(tx_done), 0);
        cmp("R1", "overflow", int'(overflow), 0);
        cmp("R1", "irq", int'(irq), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check_all();

        // R2: request follows the enable bit
        dma_en = 1'b1;
        step(0, 0, 0, 0, 0, 0);
        dma_en = 1'b0;
        step(0, 0, 0, 0, 0, 0);
        dma_en = 1'b1;

        // R6: arm on an empty bank gives a zero-length packet
        step(0, 0, 1, 0, 0, 0);
        drain_all();

        // R3, R5, R8: two full packets, then dropped writes and an ignored arm
        for (int i = 0; i < 2 * BB; i++) step(1, i, 0, 0, 0, 0);
        step(1, 8'hAA, 0, 0, 0, 0);
        step(0, 0, 1, 0, 0, 0);
        // R11: early acknowledge on an unread packet
        step(0, 0, 0, 0, 1, 0);
        step(0, 0, 0, 1, 0, 0);
        step(0, 0, 0, 0, 1, 0);
        drain_all();

        // R4: short packet waits for the arm
        for (int i = 0; i < 10; i++) step(1, 8'h30 + i, 0, 0, 0, 0);
        repeat (5) step(0, 0, 0, 0, 0, 0);
        step(0, 0, 1, 0, 0, 0);
        // R10: write and arm in the same cycle
        step(1, 8'h51, 0, 0, 0, 0);
        step(1, 8'h52, 1, 0, 0, 0);
        // R9: interrupt gating and flag clear
        irq_en = 1'b1;
        dma_en = 1'b0;
        drain_all();
        step(0, 0, 0, 0, 0, 1);
        dma_en = 1'b1;

        // constrained random phase
        for (int n = 0; n < 6000; n++) begin
            bit w, a, r, k, c;
            if (($urandom % 50) == 0) dma_en = ~dma_en;
            if (($urandom % 40) == 0) irq_en = ~irq_en;
            w = ($urandom % 100) < 60;
            a = ($urandom % 100) < 4;
            r = ($urandom % 100) < 45;
            k = ($urandom % 100) < 20;
            c = ($urandom % 100) < 3;
            step(w, $urandom % 256, a, r, k, c);
        end
        drain_all();
        finish_run();
    end
endmodule